// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point value held in a wide internal form and turns it into a 32-bit IEEE-754 single-precision word. The internal form has a class code, a sign, an unbiased exponent, a mantissa whose top bit is the implicit one, and a sticky bit that stands for any lower bits already dropped. The block is meant to sit at the end of an arithmetic pipeline. It rounds under a two-bit rounding mode and handles every special case the format has: NaN, infinity, signed zero, subnormal results, a rounding carry into the next exponent, and overflow.

The result and its status flags come out one clock after the input is accepted. The flags are underflow, overflow, inexact and operand error. On overflow, the rounding mode decides whether the output is infinity or the largest finite value.

Top module: `sp_packer`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high after that edge and shows the packed result of that input. When `in_valid` is low at an edge, `out_valid` goes low and `out_word` and the flags keep their values.
- R2: The class codes are 0 zero, 1 finite, 2 infinity and 3 NaN. A zero packs as the sign in bit 31 with bits 30..0 clear, and it raises no flag.
- R3: An infinity packs as the sign, exponent field 255 and fraction 0, and it raises no flag.
- R4: A NaN packs as the sign, exponent field 255 and the 23 mantissa bits just below the implicit one as the fraction, with fraction bit 22 (the quiet bit) forced to 1. It raises no flag.
- R5: A finite value with biased exponent (exponent + 127) from 1 to 254 packs as sign in bit 31, biased exponent in bits 30..23 and fraction in bits 22..0. The fraction is made of the 23 mantissa bits below the implicit one. An exact value raises no flag.
- R6: Rounding uses the bits below the kept fraction together with the sticky input. Mode 0 rounds to nearest, with ties to even. Mode 1 rounds toward zero. Mode 2 rounds toward plus infinity and mode 3 toward minus infinity. Inexact is set whenever any discarded bit or the sticky bit is 1.
- R7: If rounding a normal value carries out of the significand, the exponent field goes up by one and the fraction is 0.
- R8: When the biased exponent is 0 or below, the mantissa, implicit one included, is shifted right by 1 minus the biased exponent and then rounded. The word has exponent field 0 and the rounded fraction, and underflow is set even when the result is exact.
- R9: If rounding a subnormal carries into bit 23, the result is the smallest normal: exponent field 1, fraction 0, with underflow still set.
- R10: A biased exponent of 255 or more after rounding sets overflow, operand error and inexact together.
- R11: On overflow, mode 0 always gives infinity and mode 1 never does. Mode 2 gives infinity only for a positive sign and mode 3 only for a negative sign. Otherwise the result is exponent field 254 with an all-ones fraction. In every case the sign is kept.
- R12: While `rst_n` is low at a clock edge, `out_valid`, `out_word` and all flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input value is present this cycle |
| in_class | input | 2 | Class code: 0 zero, 1 finite, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign, 1 means negative |
| in_exp | input | EXP_W (10) | Unbiased exponent, two's complement |
| in_mant | input | MANT_W (32) | Mantissa, implicit one in the top bit |
| in_sticky | input | 1 | OR of bits already dropped below the mantissa |
| rnd_mode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 up, 3 down |
| out_valid | output | 1 | Result is present this cycle |
| out_word | output | 32 | Packed single-precision word |
| out_unfl | output | 1 | Underflow flag |
| out_ovfl | output | 1 | Overflow flag |
| out_inex | output | 1 | Inexact flag |
| out_operr | output | 1 | Operand-error flag |

## Verification
All state sits in the single output register stage, so a wrong alignment shift, a lost guard bit or a wrong overflow choice shows up in `out_word` or the flags on the cycle right after the input is accepted, and it can be tied to that one input. A stuck valid register shows as `out_valid` failing to follow `in_valid` one cycle later. A register that captures when it should not shows as a word that changes while no input is offered. The vectors place each rounding mode on either side of a tie, on a carry, at the edge between subnormal and normal, and on both sides of the overflow boundary, so that each error in a decision path changes at least one output bit.

// File: rtl/sp_pack_pkg.sv
// Package: shared encodings and format constants for the single-precision packer.
// Assumes: a 32-bit output word with an 8-bit exponent and a 23-bit fraction.
package sp_pack_pkg;

    localparam int SP_FRAC_W   = 23;
    localparam int SP_EXPF_W   = 8;
    localparam int SP_SIG_W    = SP_FRAC_W + 1;
    localparam int SP_BIAS     = 127;
    localparam int SP_EXP_TOP  = 255;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } val_class_e;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'd0,
        RM_TOZERO  = 2'd1,
        RM_UP      = 2'd2,
        RM_DOWN    = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic unfl;
        logic ovfl;
        logic inex;
        logic operr;
    } pack_flags_t;

endpackage

// File: rtl/sp_align.sv
// Module: sp_align
// Biases the exponent, decides normal or subnormal, and right-shifts the
// mantissa for subnormals so that the top SP_SIG_W bits are the kept
// significand, followed by one guard bit and an OR of everything below it.
// Assumes: MANT_W >= SP_SIG_W + 2 and the top mantissa bit is the implicit one.
module sp_align
    import sp_pack_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10
) (
    input  logic signed [EXP_W-1:0] exp_i,
    input  logic [MANT_W-1:0]       mant_i,
    input  logic                    sticky_i,
    output logic                    subn_o,
    output logic signed [EXP_W:0]   biased_o,
    output logic [SP_SIG_W-1:0]     keep_o,
    output logic                    guard_o,
    output logic                    rest_o
);

    localparam int BW    = EXP_W + 1;
    localparam int SHV   = SP_SIG_W + 2;
    localparam int SH_W  = $clog2(SHV + 1);
    localparam int VW    = MANT_W + SHV;
    localparam int LOW_W = VW - SP_SIG_W - 1;

    logic signed [BW-1:0] biased;
    logic [BW-1:0]        need;
    logic [SH_W-1:0]      sh;
    logic [VW-1:0]        wide;
    logic [VW-1:0]        shifted;

    // Bias the exponent with a sign extension to keep the range.
    always_comb begin
        biased = {exp_i[EXP_W-1], exp_i} + BW'(SP_BIAS);
    end

    // Subnormal when the biased exponent is zero or negative.
    always_comb begin
        subn_o = biased[BW-1] | (biased == '0);
    end

    // Shift distance for subnormals, saturated once every bit is below guard.
    always_comb begin
        need = BW'(1) - biased;
        if (!subn_o) begin
            sh = '0;
        end else if (need > BW'(SHV)) begin
            sh = SH_W'(SHV);
        end else begin
            sh = need[SH_W-1:0];
        end
    end

    // Extend with zeros so no mantissa bit leaves the vector, then shift.
    always_comb begin
        wide    = {mant_i, {SHV{1'b0}}};
        shifted = wide >> sh;
    end

    // Split the shifted vector into significand, guard and the sticky rest.
    always_comb begin
        keep_o   = shifted[VW-1 -: SP_SIG_W];
        guard_o  = shifted[LOW_W];
        rest_o   = (|shifted[LOW_W-1:0]) | sticky_i;
        biased_o = biased;
    end

endmodule

// File: rtl/sp_round.sv
// Module: sp_round
// Applies one of four rounding modes to a kept significand, using the
// guard bit and the sticky rest, and reports whether anything was lost.
// Assumes: the sum is one bit wider than the kept significand for carry-out.
module sp_round
    import sp_pack_pkg::*;
(
    input  logic [SP_SIG_W-1:0] keep_i,
    input  logic                guard_i,
    input  logic                rest_i,
    input  logic                sign_i,
    input  logic [1:0]          mode_i,
    output logic [SP_SIG_W:0]   sum_o,
    output logic                inexact_o
);

    logic lost;
    logic bump;

    // Any discarded bit makes the result inexact.
    always_comb begin
        lost      = guard_i | rest_i;
        inexact_o = lost;
    end

    // Decide whether to add one unit in the last place.
    always_comb begin
        unique case (rnd_mode_e'(mode_i))
            RM_NEAREST: bump = guard_i & (rest_i | keep_i[0]);
            RM_TOZERO:  bump = 1'b0;
            RM_UP:      bump = lost & ~sign_i;
            RM_DOWN:    bump = lost & sign_i;
            default:    bump = 1'b0;
        endcase
    end

    // Add the bump with room for a carry-out.
    always_comb begin
        sum_o = {1'b0, keep_i} + (SP_SIG_W+1)'(bump);
    end

endmodule

// File: rtl/sp_assemble.sv
// Module: sp_assemble
// Builds the final word and flags from the class, the rounded significand
// and the biased exponent, including the overflow choice by rounding mode.
// Assumes: biased exponent and rounded sum come from the same input value.
module sp_assemble
    import sp_pack_pkg::*;
#(
    parameter int EXP_W = 10
) (
    input  logic [1:0]             cls_i,
    input  logic                   sign_i,
    input  logic [SP_FRAC_W-1:0]   nan_frac_i,
    input  logic                   subn_i,
    input  logic signed [EXP_W:0]  biased_i,
    input  logic [SP_SIG_W:0]      sum_i,
    input  logic                   inexact_i,
    input  logic [1:0]             mode_i,
    output logic [31:0]            word_o,
    output pack_flags_t            flags_o
);

    localparam int EW = EXP_W + 2;
    localparam logic [SP_EXPF_W-1:0] EXP_ONES = '1;
    localparam logic [SP_FRAC_W-1:0] FRAC_ONES = '1;
    localparam logic [SP_FRAC_W-1:0] QUIET_BIT = SP_FRAC_W'(1) << (SP_FRAC_W - 1);

    logic signed [EW-1:0] exp_after;
    logic                 ovf;
    logic                 to_inf;
    logic [31:0]          word_norm;
    logic [31:0]          word_subn;
    logic [31:0]          word_ovf;

    // Exponent after a possible rounding carry, and the overflow test.
    always_comb begin
        exp_after = {biased_i[EXP_W], biased_i} + EW'(sum_i[SP_SIG_W]);
        ovf       = !subn_i && (exp_after >= EW'(SP_EXP_TOP));
    end

    // Overflow goes to infinity or to the largest finite value by mode.
    always_comb begin
        unique case (rnd_mode_e'(mode_i))
            RM_NEAREST: to_inf = 1'b1;
            RM_TOZERO:  to_inf = 1'b0;
            RM_UP:      to_inf = ~sign_i;
            RM_DOWN:    to_inf = sign_i;
            default:    to_inf = 1'b1;
        endcase
    end

    // Candidate words for the normal, subnormal and overflow paths.
    always_comb begin
        word_norm = {sign_i, exp_after[SP_EXPF_W-1:0], sum_i[SP_FRAC_W-1:0]};
        word_subn = {sign_i, {(SP_EXPF_W-1){1'b0}}, sum_i[SP_FRAC_W], sum_i[SP_FRAC_W-1:0]};
        word_ovf  = to_inf ? {sign_i, EXP_ONES, {SP_FRAC_W{1'b0}}}
                           : {sign_i, EXP_ONES - SP_EXPF_W'(1), FRAC_ONES};
    end

    // Select the word and flags by class and path.
    always_comb begin
        flags_o = '0;
        unique case (val_class_e'(cls_i))
            CLS_ZERO: begin
                word_o = {sign_i, 31'd0};
            end
            CLS_INF: begin
                word_o = {sign_i, EXP_ONES, {SP_FRAC_W{1'b0}}};
            end
            CLS_NAN: begin
                word_o = {sign_i, EXP_ONES, nan_frac_i | QUIET_BIT};
            end
            default: begin
                if (subn_i) begin
                    word_o        = word_subn;
                    flags_o.unfl  = 1'b1;
                    flags_o.inex  = inexact_i;
                end else if (ovf) begin
                    word_o        = word_ovf;
                    flags_o.ovfl  = 1'b1;
                    flags_o.inex  = 1'b1;
                    flags_o.operr = 1'b1;
                end else begin
                    word_o        = word_norm;
                    flags_o.inex  = inexact_i;
                end
            end
        endcase
    end

endmodule

// File: rtl/sp_packer.sv
// Module: sp_packer (top)
// Packs an unpacked floating-point value into a single-precision word with
// rounding, special-value handling and status flags, one cycle of latency.
// Assumes: in_mant carries the implicit one in its top bit for finite values.
module sp_packer
    import sp_pack_pkg::*;
#(
    parameter int MANT_W = 32,
    parameter int EXP_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              in_class,
    input  logic                    in_sign,
    input  logic signed [EXP_W-1:0] in_exp,
    input  logic [MANT_W-1:0]       in_mant,
    input  logic                    in_sticky,
    input  logic [1:0]              rnd_mode,
    output logic                    out_valid,
    output logic [31:0]             out_word,
    output logic                    out_unfl,
    output logic                    out_ovfl,
    output logic                    out_inex,
    output logic                    out_operr
);

    logic                   subn;
    logic signed [EXP_W:0]  biased;
    logic [SP_SIG_W-1:0]    keep;
    logic                   guard;
    logic                   rest;
    logic [SP_SIG_W:0]      sum;
    logic                   inexact;
    logic [31:0]            word_d;
    pack_flags_t            flags_d;

    sp_align #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_align (
        .exp_i    (in_exp),
        .mant_i   (in_mant),
        .sticky_i (in_sticky),
        .subn_o   (subn),
        .biased_o (biased),
        .keep_o   (keep),
        .guard_o  (guard),
        .rest_o   (rest)
    );

    sp_round u_round (
        .keep_i    (keep),
        .guard_i   (guard),
        .rest_i    (rest),
        .sign_i    (in_sign),
        .mode_i    (rnd_mode),
        .sum_o     (sum),
        .inexact_o (inexact)
    );

    sp_assemble #(
        .EXP_W (EXP_W)
    ) u_assemble (
        .cls_i      (in_class),
        .sign_i     (in_sign),
        .nan_frac_i (in_mant[MANT_W-2 -: SP_FRAC_W]),
        .subn_i     (subn),
        .biased_i   (biased),
        .sum_i      (sum),
        .inexact_i  (inexact),
        .mode_i     (rnd_mode),
        .word_o     (word_d),
        .flags_o    (flags_d)
    );

    // Valid flag follows the input valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    // Result register captures only when a new value is offered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_unfl  <= 1'b0;
            out_ovfl  <= 1'b0;
            out_inex  <= 1'b0;
            out_operr <= 1'b0;
        end else if (in_valid) begin
            out_word  <= word_d;
            out_unfl  <= flags_d.unfl;
            out_ovfl  <= flags_d.ovfl;
            out_inex  <= flags_d.inex;
            out_operr <= flags_d.operr;
        end
    end

endmodule

// File: rtl/sp_packer_chk.sv
// Module: sp_packer_chk
// Property checker for sp_packer, attached through bind below.
// Assumes: sampled on the rising clock edge with synchronous active-low reset.
module sp_packer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_class,
    input logic        in_sign,
    input logic        out_valid,
    input logic [31:0] out_word,
    input logic        out_unfl,
    input logic        out_ovfl,
    input logic        out_inex,
    input logic        out_operr
);

    // R1: an accepted input yields a valid result on the next cycle.
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no input means no valid result and a held word.
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));

    // R2: a zero packs as a signed zero with no flags.
    p_zero_pack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd0) |=>
        (out_word == {$past(in_sign), 31'd0} && !out_unfl && !out_ovfl && !out_inex && !out_operr));

    // R4: a NaN has an all-ones exponent, the quiet bit set and no flags.
    p_nan_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_class == 2'd3) |=>
        (out_word[30:22] == 9'h1FF && !out_unfl && !out_ovfl && !out_inex && !out_operr));

    // R8: an underflow result never has an exponent field above 1.
    p_unfl_small_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unfl) |-> (out_word[30:24] == 7'd0 && !out_ovfl));

    // R10: overflow always comes with operand error and inexact.
    p_no_overflow_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovfl) |-> (out_operr && out_inex));

    // R11: an overflow result is either infinity or the largest finite value.
    p_ovf_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovfl) |->
        (out_word[30:0] == 31'h7F80_0000 || out_word[30:0] == 31'h7F7F_FFFF));

    // R12: reset clears the valid output.
    p_reset_clear_r12: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == 32'd0));

endmodule

bind sp_packer sp_packer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_class  (in_class),
    .in_sign   (in_sign),
    .out_valid (out_valid),
    .out_word  (out_word),
    .out_unfl  (out_unfl),
    .out_ovfl  (out_ovfl),
    .out_inex  (out_inex),
    .out_operr (out_operr)
);

// File: tb/sp_packer_tb.sv
// Bench for sp_packer: a vector table walked by one loop, then directed
// tests for reset and output holding. Flag nibble is {unfl, ovfl, inex, operr}.
module sp_packer_tb;

    typedef struct packed {
        logic [1:0]  cls;
        logic        sgn;
        logic [9:0]  ex;
        logic [31:0] mant;
        logic        stk;
        logic [1:0]  mode;
        logic [31:0] word;
        logic [3:0]  flg;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 10'h000, 32'h8000_0000, 1'b0, 2'd0, 32'h3F80_0000, 4'b0000, 4'd5}, // R5 1.0
        '{2'd1, 1'b1, 10'h000, 32'hC000_0000, 1'b0, 2'd0, 32'hBFC0_0000, 4'b0000, 4'd5}, // R5 -1.5
        '{2'd1, 1'b0, 10'h003, 32'hA000_0000, 1'b0, 2'd0, 32'h4120_0000, 4'b0000, 4'd5}, // R5 10.0
        '{2'd1, 1'b0, 10'h000, 32'h8000_0080, 1'b0, 2'd0, 32'h3F80_0000, 4'b0010, 4'd6}, // R6 tie, even stays
        '{2'd1, 1'b0, 10'h000, 32'h8000_0180, 1'b0, 2'd0, 32'h3F80_0002, 4'b0010, 4'd6}, // R6 tie, odd rounds up
        '{2'd1, 1'b0, 10'h000, 32'h8000_01FF, 1'b0, 2'd1, 32'h3F80_0001, 4'b0010, 4'd6}, // R6 toward zero
        '{2'd1, 1'b0, 10'h000, 32'h8000_0001, 1'b0, 2'd2, 32'h3F80_0001, 4'b0010, 4'd6}, // R6 up, positive
        '{2'd1, 1'b1, 10'h000, 32'h8000_0001, 1'b0, 2'd2, 32'hBF80_0000, 4'b0010, 4'd6}, // R6 up, negative
        '{2'd1, 1'b1, 10'h000, 32'h8000_0001, 1'b0, 2'd3, 32'hBF80_0001, 4'b0010, 4'd6}, // R6 down, negative
        '{2'd1, 1'b0, 10'h000, 32'h8000_0000, 1'b1, 2'd2, 32'h3F80_0001, 4'b0010, 4'd6}, // R6 sticky only
        '{2'd1, 1'b0, 10'h000, 32'hFFFF_FF80, 1'b0, 2'd0, 32'h4000_0000, 4'b0010, 4'd7}, // R7 carry-out
        '{2'd1, 1'b0, 10'h381, 32'h8000_0000, 1'b0, 2'd0, 32'h0040_0000, 4'b1000, 4'd8}, // R8 biased 0, exact
        '{2'd1, 1'b0, 10'h36B, 32'h8000_0000, 1'b0, 2'd0, 32'h0000_0001, 4'b1000, 4'd8}, // R8 smallest subnormal
        '{2'd1, 1'b0, 10'h36A, 32'h8000_0000, 1'b0, 2'd0, 32'h0000_0000, 4'b1010, 4'd8}, // R8 half ulp, to even
        '{2'd1, 1'b0, 10'h36A, 32'h8000_0000, 1'b0, 2'd2, 32'h0000_0001, 4'b1010, 4'd8}, // R8 half ulp, up
        '{2'd1, 1'b1, 10'h200, 32'h8000_0000, 1'b0, 2'd3, 32'h8000_0001, 4'b1010, 4'd8}, // R8 far below, down
        '{2'd1, 1'b0, 10'h381, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'h0080_0000, 4'b1010, 4'd9}, // R9 to smallest normal
        '{2'd1, 1'b0, 10'h080, 32'h8000_0000, 1'b0, 2'd0, 32'h7F80_0000, 4'b0111, 4'd11}, // R11 nearest
        '{2'd1, 1'b0, 10'h080, 32'h8000_0000, 1'b0, 2'd1, 32'h7F7F_FFFF, 4'b0111, 4'd11}, // R11 toward zero
        '{2'd1, 1'b1, 10'h080, 32'h8000_0000, 1'b0, 2'd2, 32'hFF7F_FFFF, 4'b0111, 4'd11}, // R11 up, negative
        '{2'd1, 1'b1, 10'h080, 32'h8000_0000, 1'b0, 2'd3, 32'hFF80_0000, 4'b0111, 4'd11}, // R11 down, negative
        '{2'd1, 1'b0, 10'h080, 32'h8000_0000, 1'b0, 2'd2, 32'h7F80_0000, 4'b0111, 4'd11}, // R11 up, positive
        '{2'd1, 1'b0, 10'h07F, 32'hFFFF_FFFF, 1'b0, 2'd0, 32'h7F80_0000, 4'b0111, 4'd10}, // R10 by carry
        '{2'd1, 1'b0, 10'h07F, 32'hFFFF_FF00, 1'b0, 2'd0, 32'h7F7F_FFFF, 4'b0000, 4'd10}, // R10 max finite
        '{2'd2, 1'b1, 10'h000, 32'h0000_0000, 1'b0, 2'd0, 32'hFF80_0000, 4'b0000, 4'd3}, // R3 -inf
        '{2'd3, 1'b1, 10'h000, 32'hA000_0000, 1'b0, 2'd0, 32'hFFE0_0000, 4'b0000, 4'd4}, // R4 NaN payload
        '{2'd0, 1'b1, 10'h07F, 32'hFFFF_FFFF, 1'b1, 2'd2, 32'h8000_0000, 4'b0000, 4'd2}  // R2 -0
    };

    logic        clk;
    logic        rst_n;
    logic        in_valid;
    logic [1:0]  in_class;
    logic        in_sign;
    logic [9:0]  in_exp;
    logic [31:0] in_mant;
    logic        in_sticky;
    logic [1:0]  rnd_mode;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_unfl;
    logic        out_ovfl;
    logic        out_inex;
    logic        out_operr;

    int checks;
    int errors;
    bit done;

    sp_packer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_class  (in_class),
        .in_sign   (in_sign),
        .in_exp    (in_exp),
        .in_mant   (in_mant),
        .in_sticky (in_sticky),
        .rnd_mode  (rnd_mode),
        .out_valid (out_valid),
        .out_word  (out_word),
        .out_unfl  (out_unfl),
        .out_ovfl  (out_ovfl),
        .out_inex  (out_inex),
        .out_operr (out_operr)
    );

    // 250 MHz clock.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [37:0] act, input logic [37:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Offer one value at a falling edge, withdraw it at the next.
    task automatic offer(input vec_t v);
        @(negedge clk);
        in_valid  = 1'b1;
        in_class  = v.cls;
        in_sign   = v.sgn;
        in_exp    = v.ex;
        in_mant   = v.mant;
        in_sticky = v.stk;
        rnd_mode  = v.mode;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    function automatic logic [37:0] outs();
        return {out_valid, out_word, out_unfl, out_ovfl, out_inex, out_operr, 1'b0};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        checks    = 0;
        errors    = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        in_valid  = 1'b0;
        in_class  = 2'd0;
        in_sign   = 1'b0;
        in_exp    = '0;
        in_mant   = '0;
        in_sticky = 1'b0;
        rnd_mode  = 2'd0;
        repeat (3) @(negedge clk);
        // R12: reset state.
        check("R12 reset state", outs(), 38'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            offer(VECS[i]);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), outs(),
                  {1'b1, VECS[i].word, VECS[i].flg, 1'b0});
        end

        // R1: latency and hold while idle with changed inputs.
        offer(VECS[2]);
        check("R1 result after one cycle", outs(), {1'b1, 32'h4120_0000, 4'b0000, 1'b0});
        in_class = 2'd2;
        in_mant  = 32'hFFFF_FFFF;
        in_exp   = 10'h080;
        @(negedge clk);
        check("R1 idle holds word", outs(), {1'b0, 32'h4120_0000, 4'b0000, 1'b0});
        @(negedge clk);
        check("R1 idle still holds", outs(), {1'b0, 32'h4120_0000, 4'b0000, 1'b0});

        // R1: back-to-back inputs, one result per cycle.
        @(negedge clk);
        in_valid = 1'b1; in_class = 2'd1; in_sign = 1'b0; in_exp = 10'h000;
        in_mant = 32'h8000_0000; in_sticky = 1'b0; rnd_mode = 2'd0;
        @(negedge clk);
        check("R1 back-to-back first", outs(), {1'b1, 32'h3F80_0000, 4'b0000, 1'b0});
        in_class = 2'd3; in_mant = 32'h8000_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4 back-to-back NaN quiet", outs(), {1'b1, 32'h7FC0_0000, 4'b0000, 1'b0});

        // R12: reset mid-run clears a flagged result.
        offer(VECS[17]);
        check("R10 overflow before reset", outs(), {1'b1, 32'h7F80_0000, 4'b0111, 1'b0});
        rst_n = 1'b0;
        in_valid = 1'b1;
        @(negedge clk);
        check("R12 reset clears outputs", outs(), 38'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 stays clear after reset", outs(), 38'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule